// File: doc/BRIEF.md
# Serial Unlock Pattern Detector

This block watches the single-bit memory cycles aimed at a hidden device and decides when a host has written a 64-bit access key correctly. Each cycle arrives as a one-clock strobe, either read or write, qualified by a device-select input. A read cycle arms the detector and points it at the first key bit. Each write cycle then presents one data bit. A match moves the pointer on by one. A mismatch freezes the attempt until the next read.

When all 64 key bits have matched in order, the unlock flag rises. It stays high, and every strobe is ignored, until the transfer engine that follows this block pulses a clear input. A power-fail input or an accepted reset request drops the flag at any time and leaves the detector disarmed. The pointer position and the armed state are brought out as status.

Top module: `serial_unlock_detector`

## Requirements
- R1: When `rst_n` is low at a clock edge, the next state is `unlocked`=0, `armed`=0, `ptr`=0.
- R2: The key is the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, taken byte after byte with bit 0 of each byte first. Key bit k is bit (k mod 8) of byte k/8. An armed write whose `din` equals key bit `ptr` raises `ptr` by one in the next cycle.
- R3: A read cycle (`sel`=1, `rd_stb`=1) while not unlocked sets `armed`=1 and `ptr`=0 in the next cycle. This holds mid-attempt, after a mismatch, and when `wr_stb` is high in the same cycle, because the read takes priority.
- R4: An armed write whose bit mismatches clears `armed` and leaves `ptr` unchanged. Writes made while disarmed change nothing.
- R5: A matching write at `ptr`=63 sets `unlocked`=1, `armed`=0 and `ptr`=0 in the next cycle.
- R6: A cycle with `sel`=0 changes no state, whatever the strobes and `din` are.
- R7: While `unlocked`=1, read and write strobes are ignored. A `clr` pulse gives `unlocked`=0, `armed`=0, `ptr`=0 in the next cycle.
- R8: `pwr_fail`=1 or `rst_req`=1 gives `unlocked`=0, `armed`=0, `ptr`=0 in the next cycle. This takes priority over every strobe and over `clr`.
- R9: `clr` has no effect while `unlocked`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Device chip enable, qualifies the strobes |
| rd_stb | input | 1 | One-cycle read-cycle strobe |
| wr_stb | input | 1 | One-cycle write-cycle strobe |
| din | input | 1 | Data bit of the write cycle |
| clr | input | 1 | Transfer-end clear from the transfer engine |
| pwr_fail | input | 1 | Power-fail indication |
| rst_req | input | 1 | Accepted reset request |
| unlocked | output | 1 | Key fully matched |
| armed | output | 1 | Detector is accepting key bits |
| ptr | output | 6 | Index of the next key bit to compare |

## Verification
Every result of this block is due exactly one clock after the stimulus that causes it. A read arms the detector, a write moves the pointer or freezes it, the 64th match raises the flag, and a clear, power-fail or reset request drops it, each on the next edge. The bench applies each stimulus at a falling edge and lets one rising edge pass. It then compares `unlocked`, `armed` and `ptr` at the following falling edge, before it drives the next stimulus. For the key, the bench builds the expected bit from its own byte table rather than from the design.

// File: rtl/unlock_pkg.sv
// Shared types for the serial unlock detector.
// Assumes nothing beyond a single clock domain.
package unlock_pkg;
    // Kind of qualified memory cycle seen in one clock.
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_kind_t;

    // Detector state held in registers.
    typedef struct packed {
        logic unlocked;
        logic armed;
    } det_flags_t;
endpackage

// File: rtl/unlock_cycle_decode.sv
// Classifies the strobes of one clock into idle, read or write.
// Assumes strobes last one clock. A read wins over a write in the same
// cycle, and nothing counts while the device select is low.
module unlock_cycle_decode
    import unlock_pkg::*;
(
    input  logic      sel,
    input  logic      rd_stb,
    input  logic      wr_stb,
    output cyc_kind_t kind
);
    // Purpose: priority decode of the qualified strobes.
    always_comb begin
        kind = CYC_IDLE;
        if (sel) begin
            if (rd_stb) begin
                kind = CYC_READ;
            end else if (wr_stb) begin
                kind = CYC_WRITE;
            end
        end
    end
endmodule

// File: rtl/unlock_key_select.sv
// Supplies the key bit at the current pointer.
// Assumes KEY holds key bit k at position k. When KEY_BITS is not a
// power of two, indices past the end read as 0.
module unlock_key_select #(
    parameter int unsigned      KEY_BITS = 64,
    parameter logic [KEY_BITS-1:0] KEY   = '0,
    localparam int unsigned     PTR_W    = $clog2(KEY_BITS)
) (
    input  logic [PTR_W-1:0] idx,
    output logic             key_bit
);
    localparam int unsigned SPAN = 1 << PTR_W;

    generate
        if (SPAN == KEY_BITS) begin : g_exact
            // Purpose: direct index when the pointer range fits the key.
            always_comb key_bit = KEY[idx];
        end else begin : g_padded
            localparam logic [SPAN-1:0] PADDED = SPAN'(KEY);
            // Purpose: index into a zero-padded copy of the key.
            always_comb key_bit = PADDED[idx];
        end
    endgenerate
endmodule

// File: rtl/unlock_seq_ctrl.sv
// Holds the pointer, the armed flag and the unlock flag, and steps them
// on qualified cycles.
// Assumes kind comes from unlock_cycle_decode, and that pwr_fail and
// rst_req are already synchronous.
module unlock_seq_ctrl
    import unlock_pkg::*;
#(
    parameter int unsigned KEY_BITS = 64,
    localparam int unsigned PTR_W   = $clog2(KEY_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cyc_kind_t        kind,
    input  logic             din,
    input  logic             key_bit,
    input  logic             clr,
    input  logic             pwr_fail,
    input  logic             rst_req,
    output logic             unlocked,
    output logic             armed,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(KEY_BITS - 1);

    det_flags_t       flags_q, flags_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    // Purpose: next-state rule, forced clear first, then unlocked hold, then cycles.
    always_comb begin
        flags_d = flags_q;
        ptr_d   = ptr_q;
        if (pwr_fail || rst_req) begin
            flags_d = '0;
            ptr_d   = '0;
        end else if (flags_q.unlocked) begin
            if (clr) begin
                flags_d = '0;
                ptr_d   = '0;
            end
        end else begin
            unique case (kind)
                CYC_READ: begin
                    flags_d.armed = 1'b1;
                    ptr_d         = '0;
                end
                CYC_WRITE: begin
                    if (flags_q.armed) begin
                        if (din == key_bit) begin
                            if (ptr_q == LAST_IDX) begin
                                flags_d.unlocked = 1'b1;
                                flags_d.armed    = 1'b0;
                                ptr_d            = '0;
                            end else begin
                                ptr_d = ptr_q + 1'b1;
                            end
                        end else begin
                            flags_d.armed = 1'b0;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Purpose: state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            ptr_q   <= '0;
        end else begin
            flags_q <= flags_d;
            ptr_q   <= ptr_d;
        end
    end

    assign unlocked = flags_q.unlocked;
    assign armed    = flags_q.armed;
    assign ptr      = ptr_q;
endmodule

// File: rtl/serial_unlock_detector.sv
// Top level: detects a 64-bit key written one bit per write cycle after
// an arming read, and raises a flag that holds until cleared.
// Assumes one-clock strobes in the clk domain.
module serial_unlock_detector #(
    parameter int unsigned         KEY_BITS = 64,
    parameter logic [KEY_BITS-1:0] KEY      = 64'h5CA3_3AC5_5CA3_3AC5,
    localparam int unsigned        PTR_W    = $clog2(KEY_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             din,
    input  logic             clr,
    input  logic             pwr_fail,
    input  logic             rst_req,
    output logic             unlocked,
    output logic             armed,
    output logic [PTR_W-1:0] ptr
);
    import unlock_pkg::*;

    cyc_kind_t kind;
    logic      key_bit;

    unlock_cycle_decode u_decode (
        .sel    (sel),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .kind   (kind)
    );

    unlock_key_select #(
        .KEY_BITS (KEY_BITS),
        .KEY      (KEY)
    ) u_key (
        .idx     (ptr),
        .key_bit (key_bit)
    );

    unlock_seq_ctrl #(
        .KEY_BITS (KEY_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .din      (din),
        .key_bit  (key_bit),
        .clr      (clr),
        .pwr_fail (pwr_fail),
        .rst_req  (rst_req),
        .unlocked (unlocked),
        .armed    (armed),
        .ptr      (ptr)
    );
endmodule

// File: rtl/unlock_checker.sv
// Property checker for serial_unlock_detector, bound to every instance.
module unlock_checker #(
    parameter int unsigned PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic             clr,
    input logic             pwr_fail,
    input logic             rst_req,
    input logic             unlocked,
    input logic             armed,
    input logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST_IDX = '1;

    logic force_clr;
    assign force_clr = pwr_fail || rst_req;

    assert_force_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> (!unlocked && !armed && ptr == '0));

    assert_read_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_stb && !unlocked && !force_clr) |=> (armed && ptr == '0));

    assert_deselect_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !clr && !force_clr) |=> ($stable(ptr) && $stable(armed) && $stable(unlocked)));

    assert_disarmed_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_stb && !rd_stb && !armed && !unlocked && !force_clr) |=> ($stable(ptr) && !armed && !unlocked));

    assert_unlock_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(armed) && $past(ptr) == LAST_IDX));

    assert_unlocked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !clr && !force_clr) |=> (unlocked && !armed && ptr == '0));

    assert_clr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && clr && !sel && !force_clr) |=> ($stable(ptr) && $stable(armed) && !unlocked));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(unlocked && armed));

    // Covers wr_stb use in case neither strobe-based property refers to it.
    logic unused_ok;
    assign unused_ok = wr_stb;
endmodule

bind serial_unlock_detector unlock_checker #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .clr      (clr),
    .pwr_fail (pwr_fail),
    .rst_req  (rst_req),
    .unlocked (unlocked),
    .armed    (armed),
    .ptr      (ptr)
);

// File: tb/tb_serial_unlock_detector.sv
module tb_serial_unlock_detector;
    logic       clk = 1'b0;
    logic       rst_n, sel, rd_stb, wr_stb, din, clr, pwr_fail, rst_req;
    logic       unlocked, armed;
    logic [5:0] ptr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    serial_unlock_detector dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .din(din), .clr(clr), .pwr_fail(pwr_fail), .rst_req(rst_req),
        .unlocked(unlocked), .armed(armed), .ptr(ptr)
    );

    // Key bytes in compare order, bit 0 first within each (R2).
    localparam logic [7:0] KB [0:3] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};

    function automatic logic kbit(input int k);
        return KB[(k / 8) % 4][k % 8];
    endfunction

    // Vector: {rd, wr, din, sel, clr, pf, rq, exp_unl, exp_arm, exp_ptr[5:0]}
    localparam int NV = 18;
    localparam logic [14:0] VEC [0:NV-1] = '{
        {7'b1000000, 2'b00, 6'd0},  // R6 read with sel low
        {7'b1001000, 2'b01, 6'd0},  // R3 arm
        {7'b0111000, 2'b01, 6'd1},  // R2 bit0=1
        {7'b0101000, 2'b01, 6'd2},  // R2 bit1=0
        {7'b0110000, 2'b01, 6'd2},  // R6 write with sel low
        {7'b0111000, 2'b01, 6'd3},  // R2 bit2=1
        {7'b0111000, 2'b00, 6'd3},  // R4 mismatch bit3
        {7'b0101000, 2'b00, 6'd3},  // R4 ignored while disarmed
        {7'b0001100, 2'b00, 6'd3},  // R9 clr while locked
        {7'b1001000, 2'b01, 6'd0},  // R3 rearm after mismatch
        {7'b1111000, 2'b01, 6'd0},  // R3 read wins over write
        {7'b0111000, 2'b01, 6'd1},  // R2
        {7'b1001000, 2'b01, 6'd0},  // R3 mid-attempt restart
        {7'b0111000, 2'b01, 6'd1},  // R2
        {7'b0101010, 2'b00, 6'd0},  // R8 power-fail
        {7'b0111000, 2'b00, 6'd0},  // R4 disarmed write
        {7'b1001000, 2'b01, 6'd0},  // R3
        {7'b1001001, 2'b00, 6'd0}   // R8 reset request beats read
    };

    task automatic check(input string req, input logic eu, input logic ea, input logic [5:0] ep);
        n_chk++;
        if (unlocked !== eu || armed !== ea || ptr !== ep) begin
            n_fail++;
            $display("FAIL %s: got unl=%0b arm=%0b ptr=%0d, expected unl=%0b arm=%0b ptr=%0d",
                     req, unlocked, armed, ptr, eu, ea, ep);
        end
    endtask

    task automatic drive(input logic r, input logic w, input logic d, input logic s,
                         input logic c, input logic pf, input logic rq);
        rd_stb = r; wr_stb = w; din = d; sel = s; clr = c; pwr_fail = pf; rst_req = rq;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 0; wr_stb = 0; din = 0; sel = 0; clr = 0; pwr_fail = 0; rst_req = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Arms, then writes key bits 0..n-1 correctly.
    task automatic write_key(input int n);
        drive(1, 0, 0, 1, 0, 0, 0);
        for (int k = 0; k < n; k++) drive(0, 1, kbit(k), 1, 0, 0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang, expected completion");
            summary();
        end
    end

    initial begin
        rd_stb = 0; wr_stb = 0; din = 0; sel = 0; clr = 0; pwr_fail = 0; rst_req = 0;
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        check("R1 reset state", 0, 0, 6'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11],
                  VEC[i][10], VEC[i][9], VEC[i][8]);
            check($sformatf("vector %0d", i), VEC[i][7], VEC[i][6], VEC[i][5:0]);
        end

        // R2 full walk, R5 unlock on the 64th match
        drive(1, 0, 0, 1, 0, 0, 0);
        for (int k = 0; k < 63; k++) drive(0, 1, kbit(k), 1, 0, 0, 0);
        check("R2 pointer at last bit", 0, 1, 6'd63);
        drive(0, 1, kbit(63), 1, 0, 0, 0);
        check("R5 unlock", 1, 0, 6'd0);

        // R7 strobes ignored while unlocked
        drive(1, 0, 0, 1, 0, 0, 0);
        check("R7 read ignored", 1, 0, 6'd0);
        drive(0, 1, 1, 1, 0, 0, 0);
        check("R7 write ignored", 1, 0, 6'd0);
        drive(0, 0, 0, 1, 1, 0, 0);
        check("R7 clr drops flag", 0, 0, 6'd0);
        drive(0, 1, kbit(0), 1, 0, 0, 0);
        check("R7 disarmed after clr", 0, 0, 6'd0);

        // R8 power-fail while unlocked, beats clr
        write_key(64);
        check("R5 unlock again", 1, 0, 6'd0);
        drive(0, 0, 0, 1, 1, 1, 0);
        check("R8 power-fail while unlocked", 0, 0, 6'd0);

        // R4 mismatch at last bit freezes at 63
        write_key(63);
        drive(0, 1, ~kbit(63), 1, 0, 0, 0);
        check("R4 mismatch at last bit", 0, 0, 6'd63);
        drive(0, 1, kbit(63), 1, 0, 0, 0);
        check("R4 no late unlock", 0, 0, 6'd63);

        // R1 reset mid-attempt
        write_key(10);
        check("R2 ten bits", 0, 1, 6'd10);
        do_reset();
        check("R1 reset mid-attempt", 0, 0, 6'd0);

        done = 1'b1;
        summary();
    end
endmodule